// File: doc/BRIEF.md
# Page Write Collector and Commit Sequencer

This block sits behind a two-wire serial slave controller in a byte-addressed nonvolatile store. During a write transaction it gathers the data bytes the controller accepts into a small page buffer. A per-byte mark records which page slots were actually received. When the transaction ends with a stop, it copies only the marked bytes into the memory array. Then it holds a busy indication for a fixed number of clock ticks that models the internal programming time.

A transaction opens with a start strobe carrying the starting word address. The high address bits select the page and stay frozen for the whole transaction. The low bits form an in-page pointer that advances after every accepted byte and wraps inside the page, so a long burst overwrites its own earlier bytes. If the master abandons the transaction, or a stop arrives before any data byte, nothing is programmed and busy stays low. While busy is high, every request to the block is dropped.

Top module: `page_wr_seq`

## Requirements
- R1: After reset, `busy` and `mem_we` are low.
- R2: A data byte pushed as the k-th byte (counting from 0) of a transaction that started at address A is written to memory address {A[ADDR_W-1:4], (A[3:0]+k) mod 16}, with its value unchanged (PAGE_BYTES=16, so the offset is the low 4 bits).
- R3: Every memory write of one commit uses the upper address bits A[ADDR_W-1:4] latched at the start strobe. A burst never carries into the next page.
- R4: When more than 16 bytes are pushed, the offset wraps, and the byte pushed last at each offset is the one written.
- R5: Neither busy nor any memory write occurs before the stop strobe of a transaction.
- R6: After a stop that ends a transaction holding at least one byte, `busy` rises in the next cycle and stays high for exactly WR_CYCLES cycles.
- R7: Only the offsets that received a byte are written, once each. All other locations of the page keep their old contents.
- R8: A stop with no byte pushed since the start strobe raises no busy and performs no memory write.
- R9: Memory writes happen only while `busy` is high, at most one per clock, in strictly ascending offset order.
- R10: While `busy` is high, start, push, stop and abort strobes have no effect. After the window ends, a stop raises no new busy, and the stored page shows no byte from the dropped pushes.
- R11: An abort strobe discards all bytes gathered so far, so a following stop programs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Opens a write transaction at `txn_addr` |
| txn_addr | input | ADDR_W | Starting word address |
| push_valid | input | 1 | One accepted data byte is on `push_data` |
| push_data | input | DATA_W | Data byte |
| stop_commit | input | 1 | Stop condition: commit gathered bytes |
| abort_txn | input | 1 | New start without data: drop gathered bytes |
| busy | output | 1 | Programming window active, requests refused |
| mem_we | output | 1 | Memory array write enable |
| mem_addr | output | ADDR_W | Memory array write address |
| mem_wdata | output | DATA_W | Memory array write data |

## Verification
The bench sweeps every starting offset against burst lengths of 1, 2, 5, 15, 16, 17, 20 and 33 bytes. That covers short bursts, a full page and bursts that wrap once or twice, and each case is checked against a page model in the bench. A design that let the pointer carry into the upper bits would write into the neighbouring page. One that kept the first byte at a wrapped offset would leave stale data. One without a received-byte mask would overwrite untouched locations or write too many times. Strobes are also injected in the middle of the busy window, and empty and aborted transactions are tried. Together these catch a design that restarts or extends the cycle, lets late pushes corrupt the buffer it is draining, keeps a stale mask that a later stop would commit again, or starts a cycle with nothing to program.

// File: rtl/pws_pkg.sv
package pws_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_COLLECT = 2'd1,
        PH_COMMIT  = 2'd2
    } pws_phase_e;
endpackage

// File: rtl/pws_page_buf.sv
// Page data store with a per-slot "received" mark.
module pws_page_buf #(
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_hit,
    output logic              any_hit
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] data;
        logic [PAGE_BYTES-1:0]             mark;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.mark = '0;
        end else if (wr_en) begin
            st_d.data[wr_off] = wr_data;
            st_d.mark[wr_off] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data[rd_off];
    assign rd_hit  = st_q.mark[rd_off];
    assign any_hit = |st_q.mark;
endmodule

// File: rtl/pws_cycle_timer.sv
// Busy window of CYCLES clock ticks, started by a one-cycle strobe.
module pws_cycle_timer #(
    parameter int CYCLES = 24,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign last = st_q.busy && (st_q.cnt == '0);
endmodule

// File: rtl/page_wr_seq.sv
// Page write collector and commit sequencer. WR_CYCLES must be at least
// PAGE_BYTES so that the drain scan completes inside the busy window.
module page_wr_seq #(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    parameter int WR_CYCLES  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              stop_commit,
    input  logic              abort_txn,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    import pws_pkg::*;

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int UP_W   = ADDR_W - OFF_W;
    localparam int SCAN_W = OFF_W + 1;

    typedef struct packed {
        pws_phase_e        phase;
        logic [UP_W-1:0]   upper;
        logic [OFF_W-1:0]  off;
        logic [SCAN_W-1:0] scan;
    } seq_t;

    seq_t st_d, st_q;

    logic buf_clr, buf_wr, rd_hit, any_hit;
    logic tmr_start, tmr_busy, tmr_last;
    logic [DATA_W-1:0] rd_data;

    always_comb begin
        st_d      = st_q;
        buf_clr   = 1'b0;
        buf_wr    = 1'b0;
        tmr_start = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (txn_start) begin
                    st_d.phase = PH_COLLECT;
                    st_d.upper = txn_addr[ADDR_W-1:OFF_W];
                    st_d.off   = txn_addr[OFF_W-1:0];
                    buf_clr    = 1'b1;
                end
            end
            PH_COLLECT: begin
                if (txn_start) begin
                    st_d.upper = txn_addr[ADDR_W-1:OFF_W];
                    st_d.off   = txn_addr[OFF_W-1:0];
                    buf_clr    = 1'b1;
                end else if (abort_txn) begin
                    st_d.phase = PH_IDLE;
                    buf_clr    = 1'b1;
                end else if (stop_commit) begin
                    if (any_hit) begin
                        st_d.phase = PH_COMMIT;
                        st_d.scan  = '0;
                        tmr_start  = 1'b1;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end else if (push_valid) begin
                    buf_wr   = 1'b1;
                    st_d.off = st_q.off + 1'b1;
                end
            end
            PH_COMMIT: begin
                if (!st_q.scan[OFF_W]) st_d.scan = st_q.scan + 1'b1;
                if (tmr_last) begin
                    st_d.phase = PH_IDLE;
                    buf_clr    = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    pws_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_off  (st_q.off),
        .wr_data (push_data),
        .rd_off  (st_q.scan[OFF_W-1:0]),
        .rd_data (rd_data),
        .rd_hit  (rd_hit),
        .any_hit (any_hit)
    );

    pws_cycle_timer #(
        .CYCLES (WR_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy),
        .last  (tmr_last)
    );

    assign busy      = tmr_busy;
    assign mem_we    = (st_q.phase == PH_COMMIT) && !st_q.scan[OFF_W] && rd_hit;
    assign mem_addr  = {st_q.upper, st_q.scan[OFF_W-1:0]};
    assign mem_wdata = rd_data;
endmodule

// File: rtl/page_wr_seq_chk.sv
module page_wr_seq_chk #(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    parameter int WR_CYCLES  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_commit,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic [31:0] bcnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R9

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_commit)); // R5

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < 32'(WR_CYCLES))); // R6

    AST_WINDOW_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(bcnt) == 32'(WR_CYCLES - 1))); // R6

    AST_OFFSET_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[OFF_W-1:0] > $past(mem_addr[OFF_W-1:0]))); // R9

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]))); // R3
endmodule

bind page_wr_seq page_wr_seq_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W),
    .WR_CYCLES  (WR_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_commit (stop_commit),
    .busy        (busy),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr)
);

// File: tb/page_wr_seq_bench.sv
module page_wr_seq_bench;
    localparam int ADDR_W = 10;
    localparam int PAGE   = 16;
    localparam int DW     = 8;
    localparam int WRC    = 24;
    localparam int MEMN   = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_start = 1'b0;
    logic [ADDR_W-1:0] txn_addr = '0;
    logic push_valid = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic stop_commit = 1'b0;
    logic abort_txn = 1'b0;
    logic busy, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [DW-1:0] seen [MEMN];
    logic [DW-1:0] expm [MEMN];
    int wr_count = 0;
    int order_err = 0;

    always #10 clk = ~clk;

    page_wr_seq #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .DATA_W(DW), .WR_CYCLES(WRC)
    ) u_page_wr_seq (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
        .push_valid(push_valid), .push_data(push_data), .stop_commit(stop_commit),
        .abort_txn(abort_txn), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    // memory model: the write seen at a negedge lands at the following posedge
    initial begin
        int prev_off;
        bit have_prev;
        have_prev = 1'b0;
        prev_off  = 0;
        for (int i = 0; i < MEMN; i++) seen[i] = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_we) begin
                seen[mem_addr] = mem_wdata;
                wr_count++;
                if (have_prev && int'(mem_addr[3:0]) <= prev_off) order_err++;
                prev_off  = int'(mem_addr[3:0]);
                have_prev = 1'b1;
            end else if (!busy) begin
                have_prev = 1'b0;
            end
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    function automatic logic [DW-1:0] pat(int t, int i);
        return DW'(t * 37 + i * 13 + 1);
    endfunction

    task automatic cmp_page(logic [ADDR_W-1:0] a, string req);
        int bad_o;
        int bad_a;
        int bad_e;
        bad_o = -1;
        bad_a = 0;
        bad_e = 0;
        for (int o = 0; o < PAGE; o++) begin
            logic [ADDR_W-1:0] ad;
            ad = {a[ADDR_W-1:4], 4'(o)};
            if (bad_o < 0 && seen[ad] != expm[ad]) begin
                bad_o = o;
                bad_a = int'(seen[ad]);
                bad_e = int'(expm[ad]);
            end
        end
        check(bad_o < 0, req, $sformatf("page %0d contents (first bad offset %0d)", a[ADDR_W-1:4], bad_o), bad_a, bad_e);
    endtask

    task automatic run_page(int t, logic [ADDR_W-1:0] a, int n, bit poke);
        logic [DW-1:0] pb [PAGE];
        bit pm [PAGE];
        int npm;
        int w0;
        int bc;
        logic [ADDR_W-1:0] other;
        npm = 0;
        for (int o = 0; o < PAGE; o++) begin pm[o] = 1'b0; pb[o] = '0; end
        for (int i = 0; i < n; i++) begin
            int o;
            o = (int'(a[3:0]) + i) % PAGE;
            pb[o] = pat(t, i);
            pm[o] = 1'b1;
        end
        for (int o = 0; o < PAGE; o++) begin
            if (pm[o]) begin
                npm++;
                expm[{a[ADDR_W-1:4], 4'(o)}] = pb[o];
            end
        end
        other = a ^ 10'h150;
        w0 = wr_count;

        txn_start = 1'b1; txn_addr = a;
        tick();
        txn_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            push_valid = 1'b1; push_data = pat(t, i);
            tick();
        end
        push_valid = 1'b0;
        check(!busy && wr_count == w0, "R5", "busy/writes before stop", wr_count - w0, 0);

        stop_commit = 1'b1;
        tick();
        stop_commit = 1'b0;
        bc = 0;
        while (busy && bc < 1000) begin
            bc++;
            if (poke && bc == 3) begin
                txn_start = 1'b1; txn_addr = other;
                push_valid = 1'b1; push_data = ~pat(t, 0);
                stop_commit = 1'b1; abort_txn = 1'b1;
            end else begin
                txn_start = 1'b0; push_valid = 1'b0;
                stop_commit = 1'b0; abort_txn = 1'b0;
            end
            tick();
        end
        txn_start = 1'b0; push_valid = 1'b0; stop_commit = 1'b0; abort_txn = 1'b0;

        check(bc == WRC, "R6", "busy window length", bc, WRC);
        check(wr_count - w0 == npm, "R7", "writes per commit", wr_count - w0, npm);
        check(order_err == 0, "R9", "ascending write order", order_err, 0);
        cmp_page(a, n > PAGE ? "R4" : "R2 R3");
        if (poke) begin
            int w1;
            bit saw_busy;
            w1 = wr_count;
            saw_busy = 1'b0;
            stop_commit = 1'b1;
            tick();
            stop_commit = 1'b0;
            for (int k = 0; k < 6; k++) begin
                if (busy) saw_busy = 1'b1;
                tick();
            end
            check(!saw_busy && wr_count == w1, "R10", "requests during busy dropped", wr_count - w1, 0);
            cmp_page(other, "R10");
        end
    endtask

    task automatic quiet_stop(string req, int npush, bit do_abort);
        int w0;
        bit saw_busy;
        w0 = wr_count;
        saw_busy = 1'b0;
        txn_start = 1'b1; txn_addr = 10'h2A7;
        tick();
        txn_start = 1'b0;
        for (int i = 0; i < npush; i++) begin
            push_valid = 1'b1; push_data = pat(99, i);
            tick();
        end
        push_valid = 1'b0;
        if (do_abort) begin
            abort_txn = 1'b1;
            tick();
            abort_txn = 1'b0;
        end
        stop_commit = 1'b1;
        tick();
        stop_commit = 1'b0;
        for (int k = 0; k < WRC + 4; k++) begin
            if (busy) saw_busy = 1'b1;
            tick();
        end
        check(!saw_busy, req, "busy after empty stop", int'(saw_busy), 0);
        check(wr_count == w0, req, "writes after empty stop", wr_count - w0, 0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int lens [8];
        int t;
        lens = '{1, 2, 5, 15, 16, 17, 20, 33};
        for (int i = 0; i < MEMN; i++) expm[i] = '0;
        tick();
        tick();
        check(!busy, "R1", "busy in reset", int'(busy), 0);
        check(!mem_we, "R1", "mem_we in reset", int'(mem_we), 0);
        rst_n = 1'b1;
        tick();
        check(!busy && !mem_we, "R1", "idle after reset", int'(busy) + int'(mem_we), 0);

        quiet_stop("R8", 0, 1'b0);

        t = 0;
        for (int s = 0; s < PAGE; s++) begin
            for (int li = 0; li < 8; li++) begin
                logic [ADDR_W-1:0] a;
                a = {6'((t * 7) % 64), 4'(s)};
                run_page(t, a, lens[li], (t % 5) == 0);
                t++;
            end
        end

        quiet_stop("R11", 3, 1'b1);
        quiet_stop("R8", 0, 1'b0);
        run_page(500, 10'h3FE, 4, 1'b0);
        report();
    end
endmodule